// File: doc/BRIEF.md
# Collapsing Oldest-First Issue Queue

This block holds dispatched micro-ops of one operation class until their source operands are available, then hands them to execution in age order. Each entry keeps an opcode payload, a destination tag and two source physical-register tags with one ready bit each. Writeback units broadcast the tags they produce, and every stored source that matches becomes ready. An instance is built per operation class (integer, memory, floating point), with the issue width chosen per instance.

Storage collapses: when entries leave, every younger survivor slides toward slot 0. Position therefore equals age, and slot 0 always holds the oldest micro-op. Selection is a cascade of find-first stages run from slot 0 upward. Stage 0 takes the oldest ready entry. Each later stage takes the oldest ready entry that the earlier stages left. Grants come out in the same cycle the state is read, so register read can follow in the next pipeline stage. A single new micro-op can enter each cycle. It lands in the first free slot behind the survivors. A kill flush empties the queue.

Top module: `iq_collapse`

## Requirements
- R1: While reset is held and in the first cycle after it, all issue valids and `full_o` are low.
- R2: A granted issue port carries the opcode, destination tag and both source tags that the entry was dispatched with.
- R3: Port 0 grants the oldest held entry whose two ready bits are both set. An entry dispatched in cycle t can be granted in cycle t+1 at the earliest.
- R4: Port 1 grants the oldest ready entry that port 0 did not take. It is valid only when port 0 is valid, and never in the same cycle as port 0 for the same entry.
- R5: A broadcast lane with its valid bit high, whose tag equals a stored source tag, sets that source's ready bit from the next cycle on. This includes the sources of an entry dispatched in the same cycle.
- R6: `full_o` is high exactly when all 16 slots are occupied.
- R7: A dispatch presented while `full_o` or `flush_i` is high is dropped. No entry is created for it.
- R8: While `flush_i` is high, no issue port is valid, and from the next cycle the queue holds no entries.
- R9: Granted entries leave the queue in the cycle after their grant. The remaining entries keep their relative age order for all later selection.
- R10: A broadcast lane whose valid bit is low changes no ready bit, whatever its tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Kill: suppress issue now, clear all entries at the edge |
| disp_valid_i | input | 1 | Dispatch request |
| disp_op_i | input | OP_W | Opcode payload of the dispatched micro-op |
| disp_dst_i | input | TAG_W | Destination tag |
| disp_src1_i | input | TAG_W | First source tag |
| disp_rdy1_i | input | 1 | First source already available |
| disp_src2_i | input | TAG_W | Second source tag |
| disp_rdy2_i | input | 1 | Second source already available |
| wb_valid_i | input | NUM_WB | Per-lane broadcast valid |
| wb_tag_i | input | NUM_WB*TAG_W | Broadcast tags, lane w at bits [w*TAG_W +: TAG_W] |
| full_o | output | 1 | All slots occupied |
| iss_valid_o | output | NUM_ISS | Per-port grant valid |
| iss_op_o | output | NUM_ISS*OP_W | Granted opcode, port p at [p*OP_W +: OP_W] |
| iss_dst_o | output | NUM_ISS*TAG_W | Granted destination tag per port |
| iss_src1_o | output | NUM_ISS*TAG_W | Granted first source tag per port |
| iss_src2_o | output | NUM_ISS*TAG_W | Granted second source tag per port |

## Verification
The bench uses the default build: 16 slots, two issue ports, three broadcast lanes and 6-bit tags. With these values a fill to capacity takes only 16 dispatches, so the full boundary, the dropped extra dispatch and an eight-cycle two-wide drain can all be reached directly. The tag range is narrowed in the random phase. This makes broadcasts hit waiting sources often, so younger entries regularly become ready before older ones. Those cases exercise the second-port cascade and compaction by one and by two slots in the same cycle.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int unsigned IQ_DEPTH   = 16;
  localparam int unsigned IQ_TAG_W   = 6;
  localparam int unsigned IQ_OP_W    = 8;
  localparam int unsigned IQ_NUM_WB  = 3;
  localparam int unsigned IQ_NUM_ISS = 2;
endpackage

// File: rtl/iq_wakeup.sv
module iq_wakeup #(
  parameter int unsigned TAG_W  = iq_pkg::IQ_TAG_W,
  parameter int unsigned NUM_WB = iq_pkg::IQ_NUM_WB
) (
  input  logic [TAG_W-1:0]        tag_i,
  input  logic                    rdy_i,
  input  logic [NUM_WB-1:0]       wb_valid_i,
  input  logic [NUM_WB*TAG_W-1:0] wb_tag_i,
  output logic                    rdy_o
);
  logic [NUM_WB-1:0] hit;

  for (genvar w = 0; w < NUM_WB; w++) begin : g_lane
    assign hit[w] = wb_valid_i[w] && (wb_tag_i[w*TAG_W +: TAG_W] == tag_i);
  end

  assign rdy_o = rdy_i | (|hit);
endmodule

// File: rtl/iq_select.sv
module iq_select #(
  parameter int unsigned DEPTH   = iq_pkg::IQ_DEPTH,
  parameter int unsigned NUM_ISS = iq_pkg::IQ_NUM_ISS,
  localparam int unsigned IDX_W  = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]         req_i,
  output logic [NUM_ISS*DEPTH-1:0] gnt_o,
  output logic [NUM_ISS-1:0]       vld_o,
  output logic [NUM_ISS*IDX_W-1:0] idx_o
);
  logic [NUM_ISS:0][DEPTH-1:0] rem;

  assign rem[0] = req_i;

  // each stage takes the lowest (oldest) remaining request
  for (genvar p = 0; p < NUM_ISS; p++) begin : g_stage
    logic [DEPTH-1:0] gnt;
    logic [IDX_W-1:0] idx;

    assign gnt        = rem[p] & (~rem[p] + DEPTH'(1));
    assign rem[p+1]   = rem[p] & ~gnt;
    assign vld_o[p]   = |rem[p];
    assign gnt_o[p*DEPTH +: DEPTH] = gnt;

    always_comb begin
      idx = '0;
      for (int i = 0; i < DEPTH; i++) begin
        if (gnt[i]) idx = IDX_W'(i);
      end
    end

    assign idx_o[p*IDX_W +: IDX_W] = idx;
  end
endmodule

// File: rtl/iq_compact.sv
module iq_compact #(
  parameter int unsigned DEPTH   = iq_pkg::IQ_DEPTH,
  parameter int unsigned NUM_ISS = iq_pkg::IQ_NUM_ISS,
  localparam int unsigned OFF_W  = $clog2(NUM_ISS + 1),
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0]       keep_i,
  output logic [DEPTH*OFF_W-1:0] off_o,
  output logic [DEPTH-1:0]       vld_o,
  output logic [CNT_W-1:0]       cnt_o
);
  logic [DEPTH-1:0][CNT_W-1:0] shift;
  logic [DEPTH-1:0][NUM_ISS:0] match;
  logic [CNT_W-1:0]            run;

  // holes below a survivor = distance it slides; occupancy is contiguous
  always_comb begin
    run   = '0;
    cnt_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      shift[k] = run;
      if (keep_i[k]) cnt_o = cnt_o + CNT_W'(1);
      else           run   = run + CNT_W'(1);
    end
  end

  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    logic [OFF_W-1:0] off;

    for (genvar o = 0; o <= NUM_ISS; o++) begin : g_off
      if (j + o < DEPTH) begin : g_in
        assign match[j][o] = keep_i[j+o] && (shift[j+o] == CNT_W'(o));
      end else begin : g_out
        assign match[j][o] = 1'b0;
      end
    end

    always_comb begin
      off = '0;
      for (int o = 0; o <= NUM_ISS; o++) begin
        if (match[j][o]) off = OFF_W'(o);
      end
    end

    assign off_o[j*OFF_W +: OFF_W] = off;
    assign vld_o[j]                = |match[j];
  end
endmodule

// File: rtl/iq_collapse.sv
module iq_collapse #(
  parameter int unsigned DEPTH   = iq_pkg::IQ_DEPTH,
  parameter int unsigned TAG_W   = iq_pkg::IQ_TAG_W,
  parameter int unsigned OP_W    = iq_pkg::IQ_OP_W,
  parameter int unsigned NUM_WB  = iq_pkg::IQ_NUM_WB,
  parameter int unsigned NUM_ISS = iq_pkg::IQ_NUM_ISS
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     flush_i,
  input  logic                     disp_valid_i,
  input  logic [OP_W-1:0]          disp_op_i,
  input  logic [TAG_W-1:0]         disp_dst_i,
  input  logic [TAG_W-1:0]         disp_src1_i,
  input  logic                     disp_rdy1_i,
  input  logic [TAG_W-1:0]         disp_src2_i,
  input  logic                     disp_rdy2_i,
  input  logic [NUM_WB-1:0]        wb_valid_i,
  input  logic [NUM_WB*TAG_W-1:0]  wb_tag_i,
  output logic                     full_o,
  output logic [NUM_ISS-1:0]       iss_valid_o,
  output logic [NUM_ISS*OP_W-1:0]  iss_op_o,
  output logic [NUM_ISS*TAG_W-1:0] iss_dst_o,
  output logic [NUM_ISS*TAG_W-1:0] iss_src1_o,
  output logic [NUM_ISS*TAG_W-1:0] iss_src2_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned OFF_W = $clog2(NUM_ISS + 1);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned PAD   = DEPTH + NUM_ISS;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [TAG_W-1:0] dst;
    logic [TAG_W-1:0] s1;
    logic [TAG_W-1:0] s2;
    logic             r1;
    logic             r2;
  } ent_t;

  logic [DEPTH-1:0]         vld_q, vld_d, req, keep, gnt_any, cvld;
  ent_t                     ent_q [DEPTH];
  ent_t                     nxt   [DEPTH];
  ent_t                     woke  [PAD];
  ent_t                     disp_ent;
  logic [DEPTH-1:0]         wk_r1, wk_r2;
  logic                     dp_r1, dp_r2, disp_go;
  logic [NUM_ISS*DEPTH-1:0] gnt_flat;
  logic [NUM_ISS-1:0]       sel_vld;
  logic [NUM_ISS*IDX_W-1:0] sel_idx;
  logic [DEPTH*OFF_W-1:0]   off;
  logic [CNT_W-1:0]         surv_cnt;

  // ---- wakeup ----
  for (genvar i = 0; i < DEPTH; i++) begin : g_wake
    iq_wakeup #(.TAG_W(TAG_W), .NUM_WB(NUM_WB)) u_wk1 (
      .tag_i(ent_q[i].s1), .rdy_i(ent_q[i].r1),
      .wb_valid_i(wb_valid_i), .wb_tag_i(wb_tag_i), .rdy_o(wk_r1[i]));
    iq_wakeup #(.TAG_W(TAG_W), .NUM_WB(NUM_WB)) u_wk2 (
      .tag_i(ent_q[i].s2), .rdy_i(ent_q[i].r2),
      .wb_valid_i(wb_valid_i), .wb_tag_i(wb_tag_i), .rdy_o(wk_r2[i]));

    always_comb begin
      woke[i]    = ent_q[i];
      woke[i].r1 = wk_r1[i];
      woke[i].r2 = wk_r2[i];
    end

    assign req[i] = vld_q[i] & ent_q[i].r1 & ent_q[i].r2;
  end

  for (genvar i = DEPTH; i < PAD; i++) begin : g_pad
    assign woke[i] = '0;
  end

  iq_wakeup #(.TAG_W(TAG_W), .NUM_WB(NUM_WB)) u_dwk1 (
    .tag_i(disp_src1_i), .rdy_i(disp_rdy1_i),
    .wb_valid_i(wb_valid_i), .wb_tag_i(wb_tag_i), .rdy_o(dp_r1));
  iq_wakeup #(.TAG_W(TAG_W), .NUM_WB(NUM_WB)) u_dwk2 (
    .tag_i(disp_src2_i), .rdy_i(disp_rdy2_i),
    .wb_valid_i(wb_valid_i), .wb_tag_i(wb_tag_i), .rdy_o(dp_r2));

  assign disp_ent = '{op: disp_op_i, dst: disp_dst_i, s1: disp_src1_i,
                      s2: disp_src2_i, r1: dp_r1, r2: dp_r2};

  // ---- select ----
  iq_select #(.DEPTH(DEPTH), .NUM_ISS(NUM_ISS)) u_sel (
    .req_i(req), .gnt_o(gnt_flat), .vld_o(sel_vld), .idx_o(sel_idx));

  always_comb begin
    gnt_any = '0;
    for (int p = 0; p < NUM_ISS; p++) gnt_any = gnt_any | gnt_flat[p*DEPTH +: DEPTH];
  end

  assign iss_valid_o = sel_vld & {NUM_ISS{~flush_i}};

  always_comb begin
    for (int p = 0; p < NUM_ISS; p++) begin
      iss_op_o  [p*OP_W  +: OP_W]  = ent_q[sel_idx[p*IDX_W +: IDX_W]].op;
      iss_dst_o [p*TAG_W +: TAG_W] = ent_q[sel_idx[p*IDX_W +: IDX_W]].dst;
      iss_src1_o[p*TAG_W +: TAG_W] = ent_q[sel_idx[p*IDX_W +: IDX_W]].s1;
      iss_src2_o[p*TAG_W +: TAG_W] = ent_q[sel_idx[p*IDX_W +: IDX_W]].s2;
    end
  end

  // ---- compaction and insertion ----
  assign keep    = vld_q & ~gnt_any;
  assign full_o  = vld_q[DEPTH-1];  // occupancy is contiguous from slot 0
  assign disp_go = disp_valid_i & ~full_o & ~flush_i;

  iq_compact #(.DEPTH(DEPTH), .NUM_ISS(NUM_ISS)) u_cmp (
    .keep_i(keep), .off_o(off), .vld_o(cvld), .cnt_o(surv_cnt));

  for (genvar j = 0; j < DEPTH; j++) begin : g_next
    logic ins;
    assign ins      = disp_go && (surv_cnt == CNT_W'(j));
    assign vld_d[j] = cvld[j] | ins;

    always_comb begin
      nxt[j] = woke[j];
      for (int o = 1; o <= NUM_ISS; o++) begin
        if (off[j*OFF_W +: OFF_W] == OFF_W'(o)) nxt[j] = woke[j+o];
      end
      if (ins) nxt[j] = disp_ent;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vld_q <= '0;
    else if (flush_i) vld_q <= '0;
    else              vld_q <= vld_d;
  end

  always_ff @(posedge clk_i) begin
    for (int j = 0; j < DEPTH; j++) ent_q[j] <= nxt[j];
  end
endmodule

// File: rtl/iq_collapse_chk.sv
module iq_collapse_chk #(
  parameter int unsigned DEPTH   = iq_pkg::IQ_DEPTH,
  parameter int unsigned NUM_ISS = iq_pkg::IQ_NUM_ISS
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     flush_i,
  input logic                     full_i,
  input logic [NUM_ISS-1:0]       iss_valid_i,
  input logic [DEPTH-1:0]         vld_i,
  input logic [DEPTH-1:0]         req_i,
  input logic [NUM_ISS*DEPTH-1:0] gnt_i
);
  logic             overlap, multi;
  logic [DEPTH-1:0] acc, g0;

  assign g0 = gnt_i[DEPTH-1:0];

  always_comb begin
    overlap = 1'b0;
    multi   = 1'b0;
    acc     = '0;
    for (int p = 0; p < NUM_ISS; p++) begin
      overlap = overlap | (|(acc & gnt_i[p*DEPTH +: DEPTH]));
      multi   = multi | ((gnt_i[p*DEPTH +: DEPTH] & (gnt_i[p*DEPTH +: DEPTH] - DEPTH'(1))) != '0);
      acc     = acc | gnt_i[p*DEPTH +: DEPTH];
    end
  end

  AST_OLDEST_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> ((g0 != '0) && (((g0 - DEPTH'(1)) & req_i) == '0))); // R3
  AST_GNT_DISJOINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !overlap && !multi); // R4
  AST_PORT_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_i != '0) |-> iss_valid_i[0]); // R4
  AST_FLUSH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> (iss_valid_i == '0)); // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (vld_i == '0)); // R8
  AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_i && !flush_i && iss_valid_i == '0) |=> full_i); // R7
  AST_PACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((vld_i & (vld_i + DEPTH'(1))) == '0)); // R9
endmodule

bind iq_collapse iq_collapse_chk #(.DEPTH(DEPTH), .NUM_ISS(NUM_ISS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i), .full_i(full_o),
  .iss_valid_i(iss_valid_o), .vld_i(vld_q), .req_i(req), .gnt_i(gnt_flat));

// File: tb/sim_iq_collapse.sv
`timescale 1ns/1ps
module sim_iq_collapse;
  localparam int DEPTH = 16, TAG_W = 6, OP_W = 8, NWB = 3, NISS = 2;

  typedef struct {
    int op; int dst; int s1; int s2; bit r1; bit r2;
  } m_ent_t;

  logic clk_i = 1'b0, rst_ni = 1'b0, flush_i = 1'b0;
  logic disp_valid_i = 1'b0, disp_rdy1_i = 1'b0, disp_rdy2_i = 1'b0;
  logic [OP_W-1:0] disp_op_i = '0;
  logic [TAG_W-1:0] disp_dst_i = '0, disp_src1_i = '0, disp_src2_i = '0;
  logic [NWB-1:0] wb_valid_i = '0;
  logic [NWB*TAG_W-1:0] wb_tag_i = '0;
  logic full_o;
  logic [NISS-1:0] iss_valid_o;
  logic [NISS*OP_W-1:0] iss_op_o;
  logic [NISS*TAG_W-1:0] iss_dst_o, iss_src1_o, iss_src2_o;

  int n_chk = 0, n_err = 0, issued = 0;
  bit done = 0;
  string scn = "R1";
  m_ent_t mq[$];

  always #2.5 clk_i = ~clk_i;

  iq_collapse u0 (.*);

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s [%s] %s actual=%0d expected=%0d", req, scn, what, act, exp);
    end
  endtask

  function automatic bit hit(int tag, logic [NWB-1:0] v, logic [NWB*TAG_W-1:0] t);
    for (int w = 0; w < NWB; w++)
      if (v[w] && int'(t[w*TAG_W +: TAG_W]) == tag) return 1'b1;
    return 1'b0;
  endfunction

  task automatic tick();
    int e[2];
    bit fl, dv, fullb;
    logic [NWB-1:0] cv;
    logic [NWB*TAG_W-1:0] ct;
    m_ent_t n;
    e[0] = -1; e[1] = -1;
    #1;
    for (int i = 0; i < mq.size(); i++)
      if (mq[i].r1 && mq[i].r2) begin
        if (e[0] < 0) e[0] = i; else if (e[1] < 0) e[1] = i;
      end
    fl = flush_i; dv = disp_valid_i; cv = wb_valid_i; ct = wb_tag_i;
    fullb = (mq.size() == DEPTH);
    check(full_o == fullb, "R6", "full_o", int'(full_o), int'(fullb));
    for (int p = 0; p < NISS; p++) begin
      bit ev = !fl && e[p] >= 0;
      string tg = fl ? "R8" : (p == 0 ? "R3" : "R4");
      check(iss_valid_o[p] == ev, tg, $sformatf("port%0d valid", p), int'(iss_valid_o[p]), int'(ev));
      if (ev && iss_valid_o[p]) begin
        issued++;
        check(int'(iss_op_o[p*OP_W +: OP_W]) == mq[e[p]].op, "R2", $sformatf("port%0d op", p),
              int'(iss_op_o[p*OP_W +: OP_W]), mq[e[p]].op);
        check(int'(iss_dst_o[p*TAG_W +: TAG_W]) == mq[e[p]].dst, "R2", $sformatf("port%0d dst", p),
              int'(iss_dst_o[p*TAG_W +: TAG_W]), mq[e[p]].dst);
        check(int'(iss_src1_o[p*TAG_W +: TAG_W]) == mq[e[p]].s1 &&
              int'(iss_src2_o[p*TAG_W +: TAG_W]) == mq[e[p]].s2, "R2", $sformatf("port%0d srcs", p),
              int'({iss_src1_o[p*TAG_W +: TAG_W], iss_src2_o[p*TAG_W +: TAG_W]}),
              (mq[e[p]].s1 << TAG_W) | mq[e[p]].s2);
      end
    end
    n = '{op: int'(disp_op_i), dst: int'(disp_dst_i), s1: int'(disp_src1_i),
          s2: int'(disp_src2_i), r1: disp_rdy1_i, r2: disp_rdy2_i};
    @(posedge clk_i);
    if (fl) mq.delete();
    else begin
      if (e[1] >= 0) mq.delete(e[1]);
      if (e[0] >= 0) mq.delete(e[0]);
      foreach (mq[i]) begin
        if (hit(mq[i].s1, cv, ct)) mq[i].r1 = 1;
        if (hit(mq[i].s2, cv, ct)) mq[i].r2 = 1;
      end
      if (dv && !fullb) begin
        if (hit(n.s1, cv, ct)) n.r1 = 1;
        if (hit(n.s2, cv, ct)) n.r2 = 1;
        mq.push_back(n);
      end
    end
    @(negedge clk_i);
    disp_valid_i = 0; wb_valid_i = '0; flush_i = 0;
  endtask

  task automatic disp(int op, int dst, int s1, bit r1, int s2, bit r2);
    disp_valid_i = 1; disp_op_i = OP_W'(op); disp_dst_i = TAG_W'(dst);
    disp_src1_i = TAG_W'(s1); disp_rdy1_i = r1; disp_src2_i = TAG_W'(s2); disp_rdy2_i = r2;
  endtask

  task automatic bcast(int lane, int tag, bit v);
    wb_valid_i[lane] = v; wb_tag_i[lane*TAG_W +: TAG_W] = TAG_W'(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int cnt0;
    // R1: reset state
    repeat (3) @(negedge clk_i);
    check(iss_valid_o == '0 && full_o == 1'b0, "R1", "outputs in reset", int'({iss_valid_o, full_o}), 0);
    rst_ni = 1;
    tick();

    // R3/R4/R2: ready-at-dispatch entries, two-wide oldest first
    scn = "R3";
    for (int i = 0; i < 5; i++) begin disp(10 + i, 20 + i, 1, 1, 2, 1); tick(); end
    repeat (4) tick();

    // R5: younger woken first, older waits; R9 order kept
    scn = "R5";
    disp(30, 1, 40, 0, 3, 1); tick();
    disp(31, 2, 41, 0, 3, 1); tick();
    disp(32, 3, 42, 0, 43, 0); tick();
    bcast(1, 41, 1); tick();
    tick();
    bcast(0, 42, 1); bcast(2, 43, 1); tick();
    bcast(2, 40, 1); tick();
    repeat (3) tick();

    // R5: wakeup in the same cycle as dispatch
    disp(33, 4, 44, 0, 45, 0); bcast(0, 44, 1); bcast(1, 45, 1); tick();
    check(iss_valid_o[0] && int'(iss_op_o[OP_W-1:0]) == 33, "R5", "same-cycle wake issue",
          int'(iss_op_o[OP_W-1:0]), 33);
    tick();

    // R10: lane with valid low is ignored
    scn = "R10";
    disp(34, 5, 46, 0, 3, 1); tick();
    bcast(0, 46, 0); bcast(1, 46, 0); bcast(2, 46, 0); tick();
    #1 check(iss_valid_o == '0, "R10", "no wake from invalid lane", int'(iss_valid_o), 0);
    tick();
    bcast(2, 46, 1); tick(); tick();

    // R6/R7: fill, extra dispatch dropped, drain
    scn = "R7";
    for (int i = 0; i < DEPTH; i++) begin disp(100 + i, i, 50, 0, 3, 1); tick(); end
    #1 check(full_o == 1'b1, "R6", "full after 16", int'(full_o), 1);
    disp(200, 9, 3, 1, 3, 1); tick();
    bcast(0, 50, 1); tick();
    cnt0 = issued;
    repeat (10) tick();
    check(issued - cnt0 == DEPTH, "R7", "drained count", issued - cnt0, DEPTH);

    // R8: flush with content, dispatch during flush dropped
    scn = "R8";
    for (int i = 0; i < 4; i++) begin disp(60 + i, i, 51, 0, 3, 1); tick(); end
    disp(70, 7, 3, 1, 3, 1); flush_i = 1; tick();
    bcast(0, 51, 1); tick();
    #1 check(iss_valid_o == '0, "R8", "empty after flush", int'(iss_valid_o), 0);
    tick();

    // R9: random traffic
    scn = "R9";
    for (int c = 0; c < 3000; c++) begin
      if ($urandom_range(99) < 65)
        disp(c & 255, $urandom_range(63), $urandom_range(1, 10), $urandom_range(1),
             $urandom_range(1, 10), $urandom_range(1));
      for (int w = 0; w < NWB; w++)
        bcast(w, $urandom_range(1, 10), $urandom_range(99) < 25);
      if ($urandom_range(99) < 2) flush_i = 1;
      tick();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule